// File: doc/BRIEF.md
# Programmable Countdown Timer with Flag and Interrupt Shaping

This block is an 8-bit binary down-counter that measures periods in units of one of four externally supplied tick enables: 4096 Hz, 64 Hz, 1 Hz or one tick per minute. Software programs a reload value n. When the timer is enabled and n is nonzero, each selected tick decrements the count. When the count reaches zero, a sticky timer flag is raised, and the next tick reloads n and keeps counting. The period is therefore n ticks of the selected source. A reload value of zero freezes the timer.

The interrupt output has two forms, chosen by a mode bit. In level form it mirrors the flag. In pulse form it produces a short strobe every period, independent of whether the flag has been cleared. The strobe lasts until the next 8192 Hz tick when the 4096 Hz source is selected, and until the next 64 Hz tick for all other sources. An interrupt-enable bit gates the timer's contribution. An external alarm request input is ORed onto the interrupt, so a pending alarm keeps the line asserted in either mode.

Software clears the flag by writing 0 to its bit; writing 1 leaves it alone. A flag being set in the same cycle wins over a clear.

Top module: `tmr_top`

## Requirements
- R1: After reset the control register (address 1) reads 0x03, meaning timer disabled and source 1/60 Hz. The count (address 2) reads 0, and both the flag and the interrupt are low.
- R2: Writing address 2 loads both the count and the reload value. Reading address 2 returns the current count.
- R3: Control bits 1:0 pick the source: 00 = tick_4k_i, 01 = tick_64_i, 10 = tick_1_i, 11 = tick_min_i. Ticks on the unselected inputs leave the count unchanged.
- R4: When control bit 7 is 0, the timer is disabled and selected ticks leave the count unchanged.
- R5: Starting from a load of n, the count reaches 0 after n selected ticks and the flag (status bit 2) is set in that same clock. The next tick gives n-1, so the flag is set again every n ticks.
- R6: When the reload value is 0, ticks leave the count at 0 and never set the flag.
- R7: A status write with bit 2 = 0 clears the flag. A status write with bit 2 = 1 leaves the flag unchanged.
- R8: In level mode (status bit 4 = 0), irq_o is high while the flag is set and the interrupt enable (status bit 0) is 1. irq_o rises in the same clock as the flag.
- R9: In pulse mode (status bit 4 = 1), irq_o rises with each flag-set event. It falls at the first subsequent tick_8k_i when the source is 00, or at the first subsequent tick_64_i for any other source. The flag stays set after irq_o falls.
- R10: alarm_irq_i high drives irq_o high regardless of the timer state.
- R11: If the flag is being set in the same clock as a status write that would clear it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 = status, 1 = control, 2 = count/reload |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address (same map as write) |
| rd_data | output | 8 | Read data (combinational) |
| tick_4k_i | input | 1 | 4096 Hz tick enable |
| tick_64_i | input | 1 | 64 Hz tick enable |
| tick_1_i | input | 1 | 1 Hz tick enable |
| tick_min_i | input | 1 | One-per-minute tick enable |
| tick_8k_i | input | 1 | 8192 Hz tick used to time the pulse width |
| alarm_irq_i | input | 1 | External alarm interrupt request |
| tmr_flag_o | output | 1 | Sticky timer flag |
| irq_o | output | 1 | Interrupt output, active high |

## Verification
Every register write and every tick shows its effect one clock after the edge that captures it. rd_data, tmr_flag_o and irq_o can therefore be read at the falling edge that follows that capturing edge. alarm_irq_i is the exception: it reaches irq_o combinationally, so the bench samples it one time step after driving it. Each task drives its stimulus on a falling edge, holds it for exactly one rising edge, and then checks at the next falling edge. This keeps every expected value aligned to the single register stage between input and output. The same-cycle race between setting and clearing the flag is created by driving both on one falling edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;

    localparam int B_TIE  = 0;
    localparam int B_FLAG = 2;
    localparam int B_MODE = 4;

    typedef enum logic [1:0] {
        SRC_4K  = 2'b00,
        SRC_64  = 2'b01,
        SRC_1   = 2'b10,
        SRC_MIN = 2'b11
    } src_e;

    typedef struct packed {
        logic en;
        src_e src;
        logic mode;
        logic tie;
        logic flag;
    } regs_t;
endpackage

// File: rtl/tmr_tsel.sv
module tmr_tsel
    import tmr_pkg::*;
(
    input  logic       tick_4k_i,
    input  logic       tick_64_i,
    input  logic       tick_1_i,
    input  logic       tick_min_i,
    input  logic       tick_8k_i,
    input  logic       en_i,
    input  src_e       src_i,
    output logic       step_o,
    output logic       wtick_o
);
    localparam int NSRC = 4;
    logic [NSRC-1:0] tvec;

    always_comb begin
        tvec    = {tick_min_i, tick_1_i, tick_64_i, tick_4k_i};
        step_o  = en_i & tvec[src_i];
        wtick_o = (src_i == SRC_4K) ? tick_8k_i : tick_64_i;
    end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         step_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] rel_o,
    output logic         hit_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rel;
    } cst_t;

    cst_t st_d, st_q;
    logic [W-1:0] base;

    always_comb begin
        st_d  = st_q;
        hit_o = 1'b0;
        base  = (st_q.cnt == '0) ? st_q.rel : st_q.cnt;
        if (load_i) begin
            st_d.cnt = load_val_i;
            st_d.rel = load_val_i;
        end else if (step_i && st_q.rel != '0) begin
            st_d.cnt = base - 1'b1;
            hit_o    = (base == W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign rel_o = st_q.rel;
endmodule

// File: rtl/tmr_pulse.sv
module tmr_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wtick_i,
    output logic pulse_o
);
    logic pulse_d, pulse_q;

    always_comb begin
        pulse_d = pulse_q;
        if (set_i)                 pulse_d = 1'b1;
        else if (pulse_q && wtick_i) pulse_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= pulse_d;
    end

    assign pulse_o = pulse_q;
endmodule

// File: rtl/tmr_top.sv
module tmr_top
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    input  logic              tick_4k_i,
    input  logic              tick_64_i,
    input  logic              tick_1_i,
    input  logic              tick_min_i,
    input  logic              tick_8k_i,
    input  logic              alarm_irq_i,
    output logic              tmr_flag_o,
    output logic              irq_o
);
    localparam int B_EN = W - 1;

    regs_t    regs_d, regs_q;
    logic     step, wtick, hit, pulse, load;
    logic [W-1:0] cnt, rel;

    tmr_tsel u_tsel (
        .tick_4k_i (tick_4k_i),
        .tick_64_i (tick_64_i),
        .tick_1_i  (tick_1_i),
        .tick_min_i(tick_min_i),
        .tick_8k_i (tick_8k_i),
        .en_i      (regs_q.en),
        .src_i     (regs_q.src),
        .step_o    (step),
        .wtick_o   (wtick)
    );

    assign load = wr_en && (wr_addr == A_CNT);

    tmr_count #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .load_val_i(wr_data),
        .step_i    (step),
        .cnt_o     (cnt),
        .rel_o     (rel),
        .hit_o     (hit)
    );

    tmr_pulse u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hit),
        .wtick_i(wtick),
        .pulse_o(pulse)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_en && wr_addr == A_STAT) begin
            regs_d.mode = wr_data[B_MODE];
            regs_d.tie  = wr_data[B_TIE];
            regs_d.flag = regs_q.flag & wr_data[B_FLAG];
        end
        if (wr_en && wr_addr == A_CTRL) begin
            regs_d.en  = wr_data[B_EN];
            regs_d.src = src_e'(wr_data[1:0]);
        end
        if (hit) regs_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '{en: 1'b0, src: SRC_MIN, mode: 1'b0, tie: 1'b0, flag: 1'b0};
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_STAT: begin
                rd_data[B_MODE] = regs_q.mode;
                rd_data[B_FLAG] = regs_q.flag;
                rd_data[B_TIE]  = regs_q.tie;
            end
            A_CTRL: begin
                rd_data[B_EN]  = regs_q.en;
                rd_data[1:0]   = regs_q.src;
            end
            A_CNT:   rd_data = cnt;
            default: rd_data = '0;
        endcase
    end

    assign tmr_flag_o = regs_q.flag;
    assign irq_o = ((regs_q.mode ? pulse : regs_q.flag) & regs_q.tie) | alarm_irq_i;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_flag_bit,
    input logic              flag,
    input logic              irq,
    input logic              tie,
    input logic              en,
    input logic              pulse,
    input logic [W-1:0]      cnt,
    input logic [W-1:0]      rel
);
    logic clr_wr, ld_wr;
    assign clr_wr = wr_en && wr_addr == A_STAT && !wr_flag_bit;
    assign ld_wr  = wr_en && wr_addr == A_CNT;

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_wr) |=> flag);

    p_flag_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (cnt == '0));

    p_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rel == '0 && !ld_wr) |=> ($stable(cnt) && !$rose(pulse)));

    p_disabled_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !ld_wr) |=> $stable(cnt));

    p_pulse_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> (cnt == '0));

    p_irq_with_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag) && tie) |-> irq);
endmodule

bind tmr_top tmr_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_flag_bit(wr_data[2]),
    .flag       (regs_q.flag),
    .irq        (irq_o),
    .tie        (regs_q.tie),
    .en         (regs_q.en),
    .pulse      (pulse),
    .cnt        (cnt),
    .rel        (rel)
);

// File: tb/sim_tmr_top.sv
module sim_tmr_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic t4k = 1'b0, t64 = 1'b0, t1 = 1'b0, tmin = 1'b0, t8k = 1'b0;
    logic alarm = 1'b0;
    logic flag, irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick_4k_i(t4k), .tick_64_i(t64), .tick_1_i(t1), .tick_min_i(tmin),
        .tick_8k_i(t8k), .alarm_irq_i(alarm), .tmr_flag_o(flag), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    // which: 0=4k 1=64 2=1Hz 3=min 4=8k
    task automatic tick(input int which);
        @(negedge clk);
        case (which)
            0: t4k = 1'b1;
            1: t64 = 1'b1;
            2: t1 = 1'b1;
            3: tmin = 1'b1;
            default: t8k = 1'b1;
        endcase
        @(negedge clk);
        t4k = 1'b0; t64 = 1'b0; t1 = 1'b0; tmin = 1'b0; t8k = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(2'd1, v); chk("R1 ctrl", v, 8'h03);
        rd(2'd2, v); chk("R1 count", v, 8'h00);
        chk("R1 flag", {7'd0, flag}, 8'd0);
        chk("R1 irq", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_period;
        logic [7:0] v;
        wr(2'd1, 8'h82);
        wr(2'd2, 8'd3);
        rd(2'd2, v); chk("R2 load", v, 8'd3);
        tick(2); rd(2'd2, v); chk("R5 step1", v, 8'd2);
        tick(1); rd(2'd2, v); chk("R3 unselected", v, 8'd2);
        tick(2); rd(2'd2, v); chk("R5 step2", v, 8'd1);
        chk("R5 no flag early", {7'd0, flag}, 8'd0);
        tick(2); rd(2'd2, v); chk("R5 zero", v, 8'd0);
        chk("R5 flag set", {7'd0, flag}, 8'd1);
        tick(2); rd(2'd2, v); chk("R5 reload", v, 8'd2);
    endtask

    task automatic t_disable;
        logic [7:0] v;
        wr(2'd1, 8'h02);
        tick(2); rd(2'd2, v); chk("R4 disabled", v, 8'd2);
    endtask

    task automatic t_source;
        logic [7:0] v;
        wr(2'd1, 8'h80);
        wr(2'd2, 8'd5);
        tick(0); rd(2'd2, v); chk("R3 4k", v, 8'd4);
        tick(2); rd(2'd2, v); chk("R3 1Hz ignored", v, 8'd4);
        wr(2'd1, 8'h81);
        tick(1); rd(2'd2, v); chk("R3 64", v, 8'd3);
        wr(2'd1, 8'h83);
        tick(0); rd(2'd2, v); chk("R3 4k ignored", v, 8'd3);
        tick(3); rd(2'd2, v); chk("R3 min", v, 8'd2);
    endtask

    task automatic t_flag;
        wr(2'd0, 8'h00);
        chk("R7 clear", {7'd0, flag}, 8'd0);
        wr(2'd1, 8'h82);
        wr(2'd2, 8'd1);
        tick(2);
        chk("R5 n=1", {7'd0, flag}, 8'd1);
        wr(2'd0, 8'h04);
        chk("R7 write one keeps", {7'd0, flag}, 8'd1);
        wr(2'd0, 8'h00);
        chk("R7 write zero clears", {7'd0, flag}, 8'd0);
    endtask

    task automatic t_level;
        wr(2'd0, 8'h01);
        tick(2);
        chk("R8 flag", {7'd0, flag}, 8'd1);
        chk("R8 irq level", {7'd0, irq}, 8'd1);
        wr(2'd0, 8'h00);
        chk("R8 irq off", {7'd0, irq}, 8'd0);
        tick(2);
        chk("R8 flag w/o tie", {7'd0, flag}, 8'd1);
        chk("R8 gated", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_stop;
        logic [7:0] v;
        wr(2'd2, 8'd0);
        wr(2'd0, 8'h00);
        for (int i = 0; i < 3; i++) tick(2);
        rd(2'd2, v); chk("R6 count", v, 8'd0);
        chk("R6 flag", {7'd0, flag}, 8'd0);
    endtask

    task automatic t_pulse;
        wr(2'd0, 8'h11);
        wr(2'd1, 8'h82);
        wr(2'd2, 8'd1);
        tick(2);
        chk("R9 pulse rise", {7'd0, irq}, 8'd1);
        tick(4);
        chk("R9 8k ignored", {7'd0, irq}, 8'd1);
        tick(1);
        chk("R9 ends on 64", {7'd0, irq}, 8'd0);
        chk("R9 flag stays", {7'd0, flag}, 8'd1);
        wr(2'd1, 8'h80);
        wr(2'd0, 8'h11);
        wr(2'd2, 8'd1);
        tick(0);
        chk("R9 rise 4k", {7'd0, irq}, 8'd1);
        tick(1);
        chk("R9 64 ignored", {7'd0, irq}, 8'd1);
        tick(4);
        chk("R9 ends on 8k", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_alarm;
        wr(2'd0, 8'h00);
        @(negedge clk);
        alarm = 1'b1;
        #0.5;
        chk("R10 alarm", {7'd0, irq}, 8'd1);
        alarm = 1'b0;
        #0.5;
        chk("R10 alarm off", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_race;
        wr(2'd1, 8'h82);
        wr(2'd2, 8'd1);
        wr(2'd0, 8'h00);
        @(negedge clk);
        t1 = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h00;
        @(negedge clk);
        t1 = 1'b0; wr_en = 1'b0;
        chk("R11 set wins", {7'd0, flag}, 8'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_period();
        t_disable();
        t_source();
        t_flag();
        t_level();
        t_stop();
        t_pulse();
        t_alarm();
        t_race();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule